// File: doc/BRIEF.md
# I2C Temperature Sensor Target

This block is a synthesizable I2C target that stands in for a 16-bit digital temperature sensor. It is meant for board bring-up and for exercising an I2C master without real silicon. SCL and SDA are oversampled by the system clock through a synchronizer. SDA is driven through a data bit and an output-enable bit, and the pad ring resolves these as an open-drain line with a pull-up.

A master first writes a pointer byte. It then issues a repeated START and reads the temperature most significant byte followed by the least significant byte. The pointer steps from the high byte to the low byte by itself. Temperature samples arrive on a parallel input, but they become visible only on a conversion schedule: a short first conversion after reset, then a longer fixed period. A conversion that falls inside a bus transaction is dropped, so the two bytes of one read always come from the same sample.

Top module: `tsensor_i2c_target`

## Requirements
- R1: The target answers to the 7-bit address {5'b10010, strapA1, strapA0} and ACKs it by driving SDA low during the ninth SCL pulse. For any other address it leaves SDA released (line reads 1 on the ninth pulse) and stays silent until the next START.
- R2: After an address with the write bit (bit 0 = 0), the next byte is ACKed and stored as the pointer. Any further byte in the same write is NACKed and leaves the pointer unchanged.
- R3: A read returns, MSB first, the register selected by the pointer: 0x00 gives temperature bits [15:8], 0x01 gives bits [7:0], and any other pointer gives 0x00. The target changes SDA only while SCL is low.
- R4: Once a byte is sent from pointer 0x00, the pointer becomes 0x01. At 0x01 it stays at 0x01. The pointer is kept across transactions.
- R5: When the master NACKs a read byte, the target releases SDA and keeps it released until the next START, so further clocks read all ones.
- R6: A START or repeated START in any state aborts the byte in progress and restarts address matching. A STOP releases SDA one cycle after it is detected.
- R7: The temperature word is {sampleIn[12:0], 3'b000}: bit 15 is the sign, bits [14:3] are the magnitude at 0.0625 °C per step, and bits [2:0] read zero. Before the first conversion the word is 0x0000.
- R8: The first conversion loads the sample FIRST_CYCLES clocks after reset. Every later conversion loads it PERIOD_CYCLES clocks after the previous one.
- R9: A conversion that occurs while the bus is busy (between START and STOP) is discarded, and the registers keep the older sample.
- R10: While reset is asserted, and after it is released, SDA is released and the pointer is 0x00.
- R11: The target enables its SDA driver only inside a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL as seen on the pad |
| sdaIn | input | 1 | SDA as seen on the pad |
| sdaOut | output | 1 | SDA value while driving |
| sdaOe | output | 1 | SDA driver enable, low means released |
| strapA1 | input | 1 | Address strap, address bit 1 |
| strapA0 | input | 1 | Address strap, address bit 0 |
| sampleIn | input | 13 | Signed temperature sample, sign in bit 12 |

## Verification
A corrupted pointer or a stale temperature register shows up within a single read transaction, on the very next data byte clocked out. A wrong bus state (for example a missed STOP or START) shows up as a wrong ACK bit, or as SDA held low, on the ninth clock of the next byte. Errors in the conversion timer stay hidden until the tick that is early, late or dropped. For that reason the bench reads just before and just after the scheduled ticks, and once across a tick that lands inside a held transaction.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam logic [4:0] ADDR_HI = 5'b10010;
  localparam logic [7:0] PTR_MSB = 8'h00;
  localparam logic [7:0] PTR_LSB = 8'h01;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WR_IGN, ST_TX, ST_TX_ACK, ST_HOLD
  } busState_t;

  typedef struct packed {
    logic ptrWr;   // pointer byte received
    logic txLoad;  // a byte is being fetched for transmission
    logic busBusy; // between START and STOP
  } tsiStrobe_t;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       strapA1,
  input  logic       strapA0,
  input  logic [7:0] txByte,
  output tsiStrobe_t strobe,
  output logic [7:0] rxByte,
  output logic       sdaOut,
  output logic       sdaOe,
  output logic       stopDet
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclS, sdaS;
  logic sclRise, sclFall, startDet;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shReg, txSh;
  logic       rwBit, ackBit, busy;
  logic       addrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclSync[SYNC_STAGES-1];
      sdaPrev <= sdaSync[SYNC_STAGES-1];
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign addrHit  = (shReg[7:1] == {ADDR_HI, strapA1, strapA0});

  always_comb begin
    strobe.busBusy = busy;
    strobe.ptrWr   = (state == ST_PTR) && sclFall && (bitCnt == 4'd8);
    strobe.txLoad  = sclFall && (((state == ST_ADDR_ACK) && rwBit) ||
                                 ((state == ST_TX_ACK) && !ackBit));
  end

  assign rxByte = shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      shReg  <= '0;
      txSh   <= '0;
      rwBit  <= 1'b0;
      ackBit <= 1'b1;
      busy   <= 1'b0;
      sdaOe  <= 1'b0;
      sdaOut <= 1'b1;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      busy   <= 1'b1;
      sdaOe  <= 1'b0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
      busy   <= 1'b0;
      sdaOe  <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WR_IGN: begin
          if (sclRise && bitCnt < 4'd8) begin
            shReg  <= {shReg[6:0], sdaS};
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCnt <= '0;
            if (state == ST_ADDR) begin
              if (addrHit) begin
                state  <= ST_ADDR_ACK;
                rwBit  <= shReg[0];
                sdaOe  <= 1'b1;
                sdaOut <= 1'b0;
              end else begin
                state <= ST_HOLD;
              end
            end else if (state == ST_PTR) begin
              state  <= ST_PTR_ACK;
              sdaOe  <= 1'b1;
              sdaOut <= 1'b0;
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (rwBit) begin
              state  <= ST_TX;
              txSh   <= {txByte[6:0], 1'b0};
              sdaOut <= txByte[7];
              sdaOe  <= 1'b1;
              bitCnt <= '0;
            end else begin
              state <= ST_PTR;
              sdaOe <= 1'b0;
            end
          end
        end
        ST_PTR_ACK: begin
          if (sclFall) begin
            state <= ST_WR_IGN;
            sdaOe <= 1'b0;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              state  <= ST_TX_ACK;
              sdaOe  <= 1'b0;
              bitCnt <= '0;
            end else begin
              sdaOut <= txSh[7];
              txSh   <= {txSh[6:0], 1'b0};
              bitCnt <= bitCnt + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (sclRise) begin
            ackBit <= sdaS;
          end else if (sclFall) begin
            if (!ackBit) begin
              state  <= ST_TX;
              txSh   <= {txByte[6:0], 1'b0};
              sdaOut <= txByte[7];
              sdaOe  <= 1'b1;
              bitCnt <= '0;
            end else begin
              state <= ST_HOLD;
              sdaOe <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int FIRST_CYCLES  = 600000,
  parameter int PERIOD_CYCLES = 24000000,
  parameter int SAMPLE_W      = 13,
  parameter int WORD_W        = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  tsiStrobe_t          strobe,
  input  logic [7:0]          rxByte,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [7:0]          txByte,
  output logic [WORD_W-1:0]   tempWord,
  output logic [7:0]          ptrReg
);
  localparam int PAD_W  = WORD_W - SAMPLE_W;
  localparam int MAX_C  = (FIRST_CYCLES > PERIOD_CYCLES) ? FIRST_CYCLES : PERIOD_CYCLES;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  logic [CNT_W-1:0] convCnt;
  logic             convTick;

  assign convTick = (convCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         convCnt <= CNT_W'(FIRST_CYCLES - 1);
    else if (convTick) convCnt <= CNT_W'(PERIOD_CYCLES - 1);
    else               convCnt <= convCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      tempWord <= '0;
    else if (convTick && !strobe.busBusy)
      tempWord <= {sampleIn, {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ptrReg <= PTR_MSB;
    else if (strobe.ptrWr)
      ptrReg <= rxByte;
    else if (strobe.txLoad && ptrReg == PTR_MSB)
      ptrReg <= PTR_LSB;
  end

  always_comb begin
    case (ptrReg)
      PTR_MSB: txByte = tempWord[WORD_W-1:WORD_W-8];
      PTR_LSB: txByte = tempWord[7:0];
      default: txByte = 8'h00;
    endcase
  end
endmodule

// File: rtl/tsensor_i2c_target.sv
module tsensor_i2c_target
  import tsi_pkg::*;
#(
  parameter int FIRST_CYCLES  = 600000,
  parameter int PERIOD_CYCLES = 24000000,
  parameter int SAMPLE_W      = 13,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaOut,
  output logic                sdaOe,
  input  logic                strapA1,
  input  logic                strapA0,
  input  logic [SAMPLE_W-1:0] sampleIn
);
  localparam int WORD_W = 16;

  tsiStrobe_t        strobe;
  logic [7:0]        rxByte, txByte, ptrReg;
  logic [WORD_W-1:0] tempWord;
  logic              stopDet;

  tsi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strapA1(strapA1), .strapA0(strapA0), .txByte(txByte),
    .strobe(strobe), .rxByte(rxByte), .sdaOut(sdaOut), .sdaOe(sdaOe),
    .stopDet(stopDet)
  );

  tsi_datapath #(
    .FIRST_CYCLES(FIRST_CYCLES), .PERIOD_CYCLES(PERIOD_CYCLES),
    .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .sampleIn(sampleIn), .txByte(txByte), .tempWord(tempWord),
    .ptrReg(ptrReg)
  );
endmodule

// File: rtl/tsi_checker.sv
module tsi_checker (
  input logic        clk,
  input logic        rstN,
  input logic        sclIn,
  input logic        sdaOe,
  input logic        busBusy,
  input logic        stopDet,
  input logic [15:0] tempWord,
  input logic [7:0]  ptrReg
);
  a_r3_drive_on_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  a_r11_drive_in_txn: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> busBusy);

  a_r9_no_update_busy: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tempWord) |-> !$past(busBusy));

  a_r6_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

  a_r4_ptr_in_txn: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ptrReg) |-> $past(busBusy));
endmodule

bind tsensor_i2c_target tsi_checker u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .busBusy(strobe.busBusy), .stopDet(stopDet),
  .tempWord(tempWord), .ptrReg(ptrReg)
);

// File: tb/tsensor_i2c_target_tb_top.sv
module tsensor_i2c_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FIRST_C    = 4000;
  localparam int PERIOD_C   = 16000;
  localparam int HALF       = 10;
  localparam int QTR        = 5;
  localparam int WDOG       = 120000;
  localparam logic [7:0] AW = 8'h96;
  localparam logic [7:0] AR = 8'h97;

  // {strap[1:0], addr[6:0], expected ninth-bit line level}
  localparam logic [9:0] ADDR_VEC [7] = '{
    {2'b11, 7'b1001011, 1'b0},
    {2'b11, 7'b1001010, 1'b1},
    {2'b00, 7'b1001000, 1'b0},
    {2'b00, 7'b1001011, 1'b1},
    {2'b10, 7'b1001010, 1'b0},
    {2'b01, 7'b1001001, 1'b0},
    {2'b01, 7'b0001001, 1'b1}
  };

  logic clk = 0, rstN = 0;
  logic mScl = 1, mSda = 1;
  logic a1 = 1, a0 = 1;
  logic [12:0] sample = '0;
  logic dutOut, dutOe;
  wire  sdaLine = mSda & (dutOe ? dutOut : 1'b1);
  int checks = 0, errors = 0, cycCnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rstN) cycCnt <= cycCnt + 1;

  tsensor_i2c_target #(.FIRST_CYCLES(FIRST_C), .PERIOD_CYCLES(PERIOD_C)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine),
    .sdaOut(dutOut), .sdaOe(dutOe), .strapA1(a1), .strapA0(a0),
    .sampleIn(sample)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitUntil(input int c);
    while (cycCnt < c) @(negedge clk);
  endtask

  task automatic i2cStart();
    mSda = 1; wt(HALF); mScl = 1; wt(HALF); mSda = 0; wt(HALF); mScl = 0; wt(QTR);
  endtask

  task automatic i2cStop();
    mSda = 0; wt(HALF); mScl = 1; wt(HALF); mSda = 1; wt(HALF);
  endtask

  task automatic wrBit(input logic b);
    mSda = b; wt(HALF); mScl = 1; wt(HALF); mScl = 0; wt(QTR);
  endtask

  task automatic rdBit(output logic b);
    mSda = 1; wt(HALF); mScl = 1; wt(HALF/2); b = sdaLine; wt(HALF/2); mScl = 0; wt(QTR);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) wrBit(v[i]);
    rdBit(ack);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin rdBit(b); v[i] = b; end
    wrBit(nack);
  endtask

  task automatic setPtr(input logic [7:0] p);
    logic a;
    i2cStart(); sendByte(AW, a); chk("R1 addr ack", a, 0);
    sendByte(p, a); chk("R2 ptr ack", a, 0); i2cStop();
  endtask

  task automatic readPair(input logic [7:0] p, output logic [7:0] m, output logic [7:0] l);
    logic a;
    i2cStart(); sendByte(AW, a); chk("R1 addr ack", a, 0);
    sendByte(p, a); chk("R2 ptr ack", a, 0);
    i2cStart(); sendByte(AR, a); chk("R1 read addr ack", a, 0);
    recvByte(0, m); recvByte(1, l); i2cStop();
  endtask

  task automatic readCur(output logic [7:0] v);
    logic a;
    i2cStart(); sendByte(AR, a); chk("R1 read addr ack", a, 0);
    recvByte(1, v); i2cStop();
  endtask

  initial begin : watchdog
    while (cycCnt < WDOG && !done) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycCnt, WDOG);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] m, l, v;
    logic a;
    wt(3);
    chk("R10 oe in reset", dutOe, 0);
    rstN = 1;
    wt(5);
    chk("R10 oe after reset", dutOe, 0);

    // before the first conversion: zero word (R7, R8)
    readPair(8'h00, m, l);
    chk("R8 msb before first conv", m, 8'h00);
    chk("R8 lsb before first conv", l, 8'h00);
    sample = 13'h0191; // +25.0625 C
    readPair(8'h00, m, l);
    chk("R8 still zero just before tick", {m, l}, 16'h0000);
    waitUntil(FIRST_C + 100);
    readPair(8'h00, m, l);
    chk("R7 msb after first conv", m, 8'h0C);
    chk("R7 lsb low bits zero", l, 8'h88);

    // address matching against straps (R1)
    for (int i = 0; i < 7; i++) begin
      {a1, a0} = ADDR_VEC[i][9:8];
      wt(4);
      i2cStart(); sendByte({ADDR_VEC[i][7:1], 1'b0}, a); i2cStop();
      chk("R1 address table", a, ADDR_VEC[i][0]);
    end
    {a1, a0} = 2'b11;
    wt(4);

    // pointer selection and auto-increment (R3, R4)
    setPtr(8'h01);
    readCur(v); chk("R3 ptr 0x01 gives lsb", v, 8'h88);
    readCur(v); chk("R4 ptr stays at 0x01", v, 8'h88);
    setPtr(8'h00);
    i2cStart(); sendByte(AR, a); chk("R1 read addr ack", a, 0);
    recvByte(0, m); recvByte(0, l); recvByte(1, v); i2cStop();
    chk("R4 burst byte0 msb", m, 8'h0C);
    chk("R4 burst byte1 lsb", l, 8'h88);
    chk("R4 burst byte2 stays lsb", v, 8'h88);
    readPair(8'h05, m, l);
    chk("R3 other ptr reads zero", {m, l}, 16'h0000);

    // extra write byte NACKed and ignored (R2)
    i2cStart(); sendByte(AW, a); sendByte(8'h00, a);
    sendByte(8'h01, a); i2cStop();
    chk("R2 data byte nacked", a, 1);
    readCur(v); chk("R2 data byte left ptr at 0x00", v, 8'h0C);

    // release after master NACK (R5)
    setPtr(8'h00);
    i2cStart(); sendByte(AR, a); recvByte(1, m);
    recvByte(1, v); i2cStop();
    chk("R5 nacked byte", m, 8'h0C);
    chk("R5 line released after nack", v, 8'hFF);

    // START aborts a byte in progress (R6)
    i2cStart(); wrBit(1); wrBit(0); wrBit(0);
    i2cStart(); sendByte(AW, a);
    chk("R6 addr after abort acked", a, 0);
    sendByte(8'h00, a); i2cStop();
    wt(4);
    chk("R6 released after stop", dutOe, 0);

    // negative sample at second tick (R7, R8)
    sample = 13'h1FF0;
    waitUntil(FIRST_C + PERIOD_C + 100);
    readPair(8'h00, m, l);
    chk("R7 negative msb", m, 8'hFF);
    chk("R7 negative lsb", l, 8'h80);

    // tick inside a held transaction is dropped (R9)
    sample = 13'h0123;
    waitUntil(FIRST_C + 2*PERIOD_C - 1000);
    i2cStart(); sendByte(AW, a); sendByte(8'h00, a);
    waitUntil(FIRST_C + 2*PERIOD_C + 200);
    i2cStart(); sendByte(AR, a); recvByte(0, m); recvByte(1, l); i2cStop();
    chk("R9 busy tick dropped", {m, l}, 16'hFF80);
    readPair(8'h00, m, l);
    chk("R9 still old sample", {m, l}, 16'hFF80);
    waitUntil(FIRST_C + 3*PERIOD_C + 100);
    readPair(8'h00, m, l);
    chk("R8 next tick loads", {m, l}, 16'h0918);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule